// File: doc/BRIEF.md
# Deduplicating Global Access History Buffer

This block keeps an ordered record of the cache lines a data cache has touched recently, for use by a data prefetcher. It logs every access the cache observes, whether it hit or missed and whatever instruction issued it. Each access arrives as a byte address with a hit flag. The block converts the byte address to a 64-byte line frame number and compares that frame against every stored entry in parallel. It writes the frame only when no valid entry holds it already.

A new frame takes the newest slot and every older entry moves back by one. When the buffer is full, the oldest entry drops off the end. A flat readout port shows the whole history to pattern detection logic, newest entry in slot 0, with a count of valid entries. A one-cycle trigger pulse marks each cycle in which a unique entry was written, so the downstream logic knows when to re-evaluate.

Top module: `global_access_history`

## Requirements
- R1: The stored frame of an access is its byte address shifted right by 6 (address bits 31:6, 26 bits wide).
- R2: An access whose frame is not held by any valid entry is written into slot 0. Every older entry moves one slot toward the end. Both changes are visible, and `new_entry` is high for exactly one cycle, starting at the first rising edge after the access is presented.
- R3: An access whose frame matches a valid entry changes nothing. No entry is refreshed or reordered, its info field keeps its old value, the count is unchanged and `new_entry` stays low.
- R4: Hits and misses are both logged. The 2-bit info field is 2'b01 for a hit and 2'b10 for a miss.
- R5: With all DEPTH slots valid, a unique access removes the entry in the last slot, and the count stays at DEPTH.
- R6: A synchronous active-high reset clears every valid bit, the count and `new_entry`. Slots that are not valid read as all zero on the readout port.
- R7: Invalid slots never match. After reset, an access to frame 0 is logged even though the empty slots hold zero.
- R8: `hist_count` equals the number of valid slots, and the valid slots always form a contiguous run starting at slot 0.
- R9: A cycle with `acc_valid` low leaves the history, the count and the trigger unchanged (the trigger reads low).
- R10: An address that has been evicted is treated as unique again when it is accessed once more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 32 | Byte address of the access |
| acc_hit | input | 1 | 1 = cache hit, 0 = miss |
| hist_valid | output | DEPTH | Valid bit per slot, bit 0 = newest |
| hist_frame | output | DEPTH*26 | Frame per slot, slot i at bits [i*26 +: 26] |
| hist_info | output | DEPTH*2 | Info per slot, slot i at bits [i*2 +: 2] |
| hist_count | output | $clog2(DEPTH+1) | Number of valid slots |
| new_entry | output | 1 | One-cycle pulse after a unique entry is written |

## Verification
Every result of an access is due one rising edge after the access is presented. The history slots, the count and the `new_entry` pulse all change at that edge, and the pulse is gone after the following edge. The bench drives each access on a falling edge, removes it on the next falling edge and samples all outputs at that point. That point is the only half-cycle in which the pulse for that access is visible. A reference list of the expected history is kept in the bench, updated by the rules of R2, R3 and R5 and compared slot by slot after every access.

// File: rtl/ghb_pkg.sv
package ghb_pkg;
    localparam int ADDR_W     = 32;
    localparam int LINE_SHIFT = 6;
    localparam int FRAME_W    = ADDR_W - LINE_SHIFT;
    localparam int INFO_W     = 2;

    typedef logic [ADDR_W-1:0]  byte_addr_t;
    typedef logic [FRAME_W-1:0] frame_t;
    typedef logic [INFO_W-1:0]  info_t;

    typedef enum logic [INFO_W-1:0] {
        INFO_NONE = 2'b00,
        INFO_HIT  = 2'b01,
        INFO_MISS = 2'b10
    } info_e;

    typedef struct packed {
        logic   valid;
        frame_t frame;
        info_t  info;
    } slot_t;

    function automatic frame_t frame_of(input byte_addr_t a);
        return a[ADDR_W-1:LINE_SHIFT];
    endfunction

    function automatic info_t info_of(input logic hit);
        info_e code;
        code = hit ? INFO_HIT : INFO_MISS;
        return info_t'(code);
    endfunction
endpackage

// File: rtl/ghb_match.sv
module ghb_match
    import ghb_pkg::*;
#(
    parameter int DEPTH = 128
) (
    input  slot_t              slots [DEPTH],
    input  frame_t             probe,
    output logic [DEPTH-1:0]   hit_vec,
    output logic               hit_any
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign hit_vec[i] = slots[i].valid && (slots[i].frame == probe);
    end
    assign hit_any = |hit_vec;
endmodule

// File: rtl/ghb_store.sv
module ghb_store
    import ghb_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  frame_t           push_frame,
    input  info_t            push_info,
    output slot_t            slots [DEPTH],
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    slot_t head;
    always_comb begin
        head.valid = 1'b1;
        head.frame = push_frame;
        head.info  = push_info;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        slot_t nxt;
        if (i == 0) begin : g_head
            assign nxt = head;
        end else begin : g_body
            assign nxt = slots[i-1];
        end
        always_ff @(posedge clk) begin
            if (rst) begin
                slots[i] <= '0;
            end else if (push) begin
                slots[i] <= nxt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (push && count != FULL) begin
            count <= count + 1'b1;
        end
    end

    logic [DEPTH-1:0] valid_vec;
    for (genvar i = 0; i < DEPTH; i++) begin : g_vld
        assign valid_vec[i] = slots[i].valid;
    end

    // R8: counter and valid bits are kept by separate registers
    assert_count_matches_valid_R8: assert property (@(posedge clk) disable iff (rst)
        CNT_W'($countones(valid_vec)) == count);
    // R5: the count never exceeds the depth
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        count <= FULL);
    // R8: valid run is contiguous from slot 0 (low bits set, then zeros)
    assert_contiguous_R8: assert property (@(posedge clk) disable iff (rst)
        ((valid_vec + 1'b1) & valid_vec) == '0);
endmodule

// File: rtl/global_access_history.sv
module global_access_history
    import ghb_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         acc_valid,
    input  logic [ADDR_W-1:0]            acc_addr,
    input  logic                         acc_hit,
    output logic [DEPTH-1:0]             hist_valid,
    output logic [DEPTH*FRAME_W-1:0]     hist_frame,
    output logic [DEPTH*INFO_W-1:0]      hist_info,
    output logic [CNT_W-1:0]             hist_count,
    output logic                         new_entry
);
    slot_t            slots [DEPTH];
    frame_t           probe;
    info_t            probe_info;
    logic [DEPTH-1:0] hit_vec;
    logic             hit_any;
    logic             push;

    assign probe      = frame_of(acc_addr);
    assign probe_info = info_of(acc_hit);

    ghb_match #(.DEPTH(DEPTH)) u_match (
        .slots   (slots),
        .probe   (probe),
        .hit_vec (hit_vec),
        .hit_any (hit_any)
    );

    assign push = acc_valid && !hit_any;

    ghb_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst        (rst),
        .push       (push),
        .push_frame (probe),
        .push_info  (probe_info),
        .slots      (slots),
        .count      (hist_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            new_entry <= 1'b0;
        end else begin
            new_entry <= push;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_out
        assign hist_valid[i]                      = slots[i].valid;
        assign hist_frame[i*FRAME_W +: FRAME_W]   = slots[i].valid ? slots[i].frame : '0;
        assign hist_info[i*INFO_W +: INFO_W]      = slots[i].valid ? slots[i].info  : '0;
    end

    // R3: no frame is ever held twice
    assert_single_match_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));
    // R3: a duplicate access leaves count and trigger untouched
    assert_dup_no_trigger_R3: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && hit_any) |=> (!new_entry && $stable(hist_count)));
    // R2: after a trigger the newest slot carries the presented frame
    assert_head_written_R2: assert property (@(posedge clk) disable iff (rst)
        new_entry |-> (hist_valid[0] && hist_frame[FRAME_W-1:0] == $past(probe)));
    // R9: idle cycles change nothing
    assert_idle_stable_R9: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> (!new_entry && $stable(hist_count) && $stable(hist_valid)));
    // R4: stored info is always a hit or miss code
    assert_info_code_R4: assert property (@(posedge clk) disable iff (rst)
        hist_valid[0] |-> (hist_info[INFO_W-1:0] == 2'b01 || hist_info[INFO_W-1:0] == 2'b10));
endmodule

// File: tb/global_access_history_test.sv
module global_access_history_test;
    localparam int DEPTH = 128;
    localparam int CLK_PERIOD = 10;
    localparam int FW = 26;
    localparam int CW = $clog2(DEPTH + 1);

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                acc_valid = 1'b0;
    logic [31:0]         acc_addr = '0;
    logic                acc_hit = 1'b0;
    logic [DEPTH-1:0]    hist_valid;
    logic [DEPTH*FW-1:0] hist_frame;
    logic [DEPTH*2-1:0]  hist_info;
    logic [CW-1:0]       hist_count;
    logic                new_entry;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [FW-1:0] exp_frame [DEPTH];
    logic [1:0]    exp_info  [DEPTH];
    int            exp_cnt;
    logic          exp_trig;

    global_access_history #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_hit(acc_hit), .hist_valid(hist_valid), .hist_frame(hist_frame),
        .hist_info(hist_info), .hist_count(hist_count), .new_entry(new_entry)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) begin
            exp_frame[i] = '0;
            exp_info[i] = '0;
        end
        exp_cnt = 0;
        exp_trig = 0;
    endtask

    task automatic model_access(input logic [31:0] a, input logic h);
        logic [FW-1:0] f;
        bit found;
        f = a[31:6];
        found = 0;
        for (int i = 0; i < exp_cnt; i++) if (exp_frame[i] == f) found = 1;
        exp_trig = !found;
        if (!found) begin
            for (int i = DEPTH-1; i > 0; i--) begin
                exp_frame[i] = exp_frame[i-1];
                exp_info[i] = exp_info[i-1];
            end
            exp_frame[0] = f;
            exp_info[0] = h ? 2'b01 : 2'b10;
            if (exp_cnt < DEPTH) exp_cnt++;
        end
    endtask

    task automatic check_all(input string req);
        int bad;
        bad = -1;
        check(int'(hist_count) == exp_cnt, {req, " count"}, longint'(hist_count), longint'(exp_cnt));
        check(new_entry == exp_trig, {req, " trigger"}, longint'(new_entry), longint'(exp_trig));
        for (int i = DEPTH-1; i >= 0; i--) begin
            logic v;
            logic [FW-1:0] ef;
            logic [1:0] ei;
            v = (i < exp_cnt);
            ef = v ? exp_frame[i] : '0;
            ei = v ? exp_info[i] : '0;
            if (hist_valid[i] != v || hist_frame[i*FW +: FW] != ef || hist_info[i*2 +: 2] != ei)
                bad = i;
        end
        if (bad >= 0)
            check(0, {req, " slot"}, longint'(hist_frame[bad*FW +: FW]), longint'(exp_frame[bad]));
        else
            check(1, req, 0, 0);
    endtask

    task automatic do_access(input logic [31:0] a, input logic h, input string req);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_addr = a;
        acc_hit = h;
        @(negedge clk);
        acc_valid = 1'b0;
        model_access(a, h);
        check_all(req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    task automatic test_reset();
        do_reset();
        check(hist_valid == '0, "R6 valid cleared", longint'(hist_valid[63:0]), 0);
        check(hist_frame == '0 && hist_info == '0, "R6 readout zero", longint'(hist_frame[63:0]), 0);
        check_all("R6");
    endtask

    task automatic test_zero_frame();
        do_access(32'h0000_0020, 1'b1, "R7 frame 0 logged");
        check(hist_frame[FW-1:0] == '0 && hist_count == 1, "R7 head", longint'(hist_count), 1);
    endtask

    task automatic test_unique_and_shift();
        do_access(32'h0001_0040, 1'b0, "R2 insert");
        check(hist_frame[FW-1:0] == 26'h0000401, "R1 shift by 6", longint'(hist_frame[FW-1:0]), 26'h401);
        check(hist_info[1:0] == 2'b10, "R4 miss code", longint'(hist_info[1:0]), 2);
        do_access(32'h0001_0083, 1'b1, "R2 second insert");
        check(hist_info[1:0] == 2'b01, "R4 hit code", longint'(hist_info[1:0]), 1);
        @(negedge clk);
        check(new_entry == 1'b0, "R2 pulse one cycle", longint'(new_entry), 0);
    endtask

    task automatic test_duplicate();
        do_access(32'h0001_007F, 1'b1, "R3 duplicate of older line");
        check(hist_info[FW > 0 ? 3 : 3 -: 2] == 2'b10, "R3 info not refreshed", longint'(hist_info[3:2]), 2);
        do_access(32'h0001_0080, 1'b0, "R3 duplicate of newest line");
    endtask

    task automatic test_idle();
        logic [CW-1:0] c0;
        c0 = hist_count;
        repeat (5) @(negedge clk);
        check(hist_count == c0 && new_entry == 1'b0, "R9 idle", longint'(hist_count), longint'(c0));
        check_all("R9 idle contents");
    endtask

    task automatic test_fill_and_evict();
        for (int k = 0; k < DEPTH + 3; k++)
            do_access(32'h1000_0000 + k * 64, k[0], "R5 fill");
        check(int'(hist_count) == DEPTH, "R5 count saturates", longint'(hist_count), DEPTH);
        check(hist_frame[(DEPTH-1)*FW +: FW] == 26'(32'h1000_00C0 >> 6), "R5 oldest slot",
              longint'(hist_frame[(DEPTH-1)*FW +: FW]), longint'(32'h1000_00C0 >> 6));
        do_access(32'h1000_0000, 1'b0, "R10 evicted line re-enters");
        check(new_entry == 1'b1, "R10 trigger", longint'(new_entry), 1);
        do_access(32'h1000_0000 + (DEPTH + 2) * 64, 1'b1, "R3 duplicate when full");
        check_all("R8 after full");
    endtask

    initial begin
        model_reset();
        test_reset();
        test_zero_frame();
        test_unique_and_shift();
        test_duplicate();
        test_idle();
        test_fill_and_evict();
        test_reset();
        test_zero_frame();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule